// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital side of a multi-channel successive-approximation analog-to-digital converter. Software reaches it through a small word-addressed register bus. When software writes the control word with the power bit set and a valid channel number, the block powers the analog front end and routes that channel to it. It then waits a programmable number of clock periods so the analog parts can settle. After that it runs a binary search that resolves one result bit per clock.

During the search the block drives a trial code onto a DAC and reads back a single comparator bit. The comparator, the DAC and the analog multiplexer sit outside the block and appear here only as digital ports. When the last bit is resolved, the block latches the code into the result register. It also sets a sticky completion flag, which sits in the control word, and raises the interrupt line if interrupts are enabled. Writing zero to the control word powers the front end down, aborts any conversion in progress and clears the flag.

Top module: `sar_adc_ctrl`

## Requirements
- R1: Word addresses decode as 0 = result, 1 = status, 2 = control, 3 = settle delay. The settle-delay word reads back the low DLY_W bits last written, and the bits above them read as zero. After reset every register reads zero.
- R2: Control word fields are channel at bits [2:0], power at bit 3, interrupt enable at bit 5, and completion flag at bit 6. The completion flag is read-only. Bits 4 and 7..31 read as zero whatever was written.
- R3: An accepted control write with power = 1 starts a conversion. From then on `afe_power` is 1 and `afe_chan` equals the written channel. Status bit 0 (busy) reads 1 from the accepting edge until the completion flag rises.
- R4: With settle value D, the completion flag becomes visible max(D,1) + RES_BITS clock edges after the edge that accepted the start write.
- R5: The search runs MSB first. `dac_code` is 0 outside a conversion, and it equals 2^(RES_BITS-1) in the first search cycle. A trial bit is kept when `cmp_in` is 1 (input at or above the DAC level). The final code is therefore the largest code the input reaches.
- R6: The result word holds the code in its low RES_BITS bits, with zeros above. It does not change while the completion flag is high.
- R7: The completion flag is set at the end of a search and stays set until the next accepted control write. `irq` equals the flag AND interrupt enable.
- R8: An accepted control write with power = 0 powers down (`afe_power` = 0), aborts any settle wait or search (busy = 0, `dac_code` = 0) and clears the completion flag.
- R9: A control write whose channel field is NUM_CH or above is discarded. The control word, flag, busy state and front-end outputs stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational from bus_addr) |
| afe_power | output | 1 | Analog front-end power enable |
| afe_chan | output | 3 | Analog multiplexer channel select |
| dac_code | output | RES_BITS | Trial code to the DAC |
| cmp_in | input | 1 | Comparator: 1 when input is at or above the DAC level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a control write that lands while the block is inside its settle wait or in the middle of a search. That window lasts only a handful of cycles and moves with the programmed delay. The bench counts cycles from the accepting edge to place an abort write in mid-search, and places rejected channel writes right after a completed conversion so that a wrongly cleared flag would show at once. The comparator is modelled in the bench as a compare of a per-channel input value against `dac_code`. A full sweep of one channel across every code then shows both the search order and the channel routing.

// File: rtl/sar_pkg.sv
package sar_pkg;

    localparam int REG_W = 32;

    // word addresses
    localparam logic [1:0] A_RESULT = 2'd0;
    localparam logic [1:0] A_STATUS = 2'd1;
    localparam logic [1:0] A_CTRL   = 2'd2;
    localparam logic [1:0] A_DELAY  = 2'd3;

    // control and status field positions
    localparam int F_CH_W = 3;
    localparam int F_PWR  = 3;
    localparam int F_IE   = 5;
    localparam int F_DONE = 6;
    localparam int F_BUSY = 0;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_WAIT,
        SQ_CONV
    } sq_state_e;

endpackage

// File: rtl/sar_regs.sv
module sar_regs
    import sar_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int NUM_CH   = 6,
    parameter int DLY_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [1:0]          bus_addr,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [RES_BITS-1:0] result_i,
    input  logic                busy_i,
    input  logic                end_i,
    output logic                start_o,
    output logic                stop_o,
    output logic [F_CH_W-1:0]   chan_o,
    output logic                pwr_o,
    output logic                done_o,
    output logic                irq_o,
    output logic [DLY_W-1:0]    dly_o
);

    localparam logic [F_CH_W:0] CH_LIM = (F_CH_W+1)'(NUM_CH);

    typedef struct packed {
        logic [F_CH_W-1:0] chan;
        logic              pwr;
        logic              ie;
        logic              done;
        logic [DLY_W-1:0]  dly;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  ctrl_sel, ch_ok, accept;
    logic  unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        ctrl_sel = bus_we && (bus_addr == A_CTRL);
        ch_ok    = {1'b0, bus_wdata[F_CH_W-1:0]} < CH_LIM;
        accept   = ctrl_sel && ch_ok;
        regs_d   = regs_q;
        if (accept) begin
            regs_d.chan = bus_wdata[F_CH_W-1:0];
            regs_d.pwr  = bus_wdata[F_PWR];
            regs_d.ie   = bus_wdata[F_IE];
            regs_d.done = 1'b0;
        end else if (end_i) begin
            regs_d.done = 1'b1;
        end
        if (bus_we && (bus_addr == A_DELAY)) begin
            regs_d.dly = bus_wdata[DLY_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign start_o = accept && bus_wdata[F_PWR];
    assign stop_o  = accept && !bus_wdata[F_PWR];
    assign chan_o  = regs_q.chan;
    assign pwr_o   = regs_q.pwr;
    assign done_o  = regs_q.done;
    assign irq_o   = regs_q.done && regs_q.ie;
    assign dly_o   = regs_q.dly;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_RESULT: bus_rdata[RES_BITS-1:0] = result_i;
            A_STATUS: bus_rdata[F_BUSY] = busy_i;
            A_CTRL: begin
                bus_rdata[F_CH_W-1:0] = regs_q.chan;
                bus_rdata[F_PWR]      = regs_q.pwr;
                bus_rdata[F_IE]       = regs_q.ie;
                bus_rdata[F_DONE]     = regs_q.done;
            end
            default: bus_rdata[DLY_W-1:0] = regs_q.dly;
        endcase
    end

    // R7: flag holds until the next accepted control write
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.done && !accept) |=> regs_q.done);

    // R6: result frozen while the flag is up
    a_r6_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.done && !accept) |=> $stable(result_i));

    // R9: stored channel always in range
    a_r9_chan_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, regs_q.chan} < CH_LIM);

    // R9: rejected write leaves control state alone
    a_r9_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_sel && !ch_ok) |=> $stable({regs_q.chan, regs_q.pwr, regs_q.ie, regs_q.done}));

    // R8: power-down write clears flag and power
    a_r8_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> (!regs_q.done && !regs_q.pwr));

endmodule

// File: rtl/sar_seq.sv
module sar_seq
    import sar_pkg::*;
#(
    parameter int DLY_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             end_i,
    output logic             busy_o,
    output logic             go_o
);

    localparam logic [DLY_W-1:0] CNT_ONE = DLY_W'(1);

    typedef struct packed {
        sq_state_e        st;
        logic [DLY_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        go_o  = 1'b0;
        if (start_i) begin
            seq_d.st  = SQ_WAIT;
            seq_d.cnt = dly_i;
        end else if (stop_i) begin
            seq_d.st  = SQ_IDLE;
            seq_d.cnt = '0;
        end else begin
            case (seq_q.st)
                SQ_WAIT: begin
                    if (seq_q.cnt <= CNT_ONE) begin
                        seq_d.st  = SQ_CONV;
                        seq_d.cnt = '0;
                        go_o      = 1'b1;
                    end else begin
                        seq_d.cnt = seq_q.cnt - CNT_ONE;
                    end
                end
                SQ_CONV: begin
                    if (end_i) seq_d.st = SQ_IDLE;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SQ_IDLE, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign busy_o = (seq_q.st != SQ_IDLE);

    // R4: settle counter steps down by one per clock
    a_r4_wait_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_WAIT && !start_i && !stop_i && seq_q.cnt > CNT_ONE)
        |=> (seq_q.st == SQ_WAIT && seq_q.cnt == $past(seq_q.cnt) - CNT_ONE));

    // R4: search begins only from the settle wait
    a_r4_conv_after_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == SQ_IDLE && !start_i) |=> (seq_q.st != SQ_CONV));

endmodule

// File: rtl/sar_search.sv
module sar_search #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go_i,
    input  logic                kill_i,
    input  logic                cmp_i,
    output logic [RES_BITS-1:0] dac_o,
    output logic [RES_BITS-1:0] result_o,
    output logic                end_o
);

    localparam logic [RES_BITS-1:0] MSB_BIT = {1'b1, {(RES_BITS-1){1'b0}}};

    typedef struct packed {
        logic                active;
        logic [RES_BITS-1:0] mask;
        logic [RES_BITS-1:0] work;
        logic [RES_BITS-1:0] result;
    } srch_t;

    srch_t srch_d, srch_q;
    logic [RES_BITS-1:0] kept;

    always_comb begin
        srch_d = srch_q;
        kept   = srch_q.work | (cmp_i ? srch_q.mask : '0);
        end_o  = 1'b0;
        if (kill_i) begin
            srch_d.active = 1'b0;
            srch_d.mask   = '0;
            srch_d.work   = '0;
        end else if (go_i) begin
            srch_d.active = 1'b1;
            srch_d.mask   = MSB_BIT;
            srch_d.work   = '0;
        end else if (srch_q.active) begin
            srch_d.work = kept;
            if (srch_q.mask[0]) begin
                srch_d.result = kept;
                srch_d.active = 1'b0;
                srch_d.mask   = '0;
                srch_d.work   = '0;
                end_o         = 1'b1;
            end else begin
                srch_d.mask = srch_q.mask >> 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) srch_q <= '0;
        else        srch_q <= srch_d;
    end

    assign dac_o    = srch_q.active ? (srch_q.work | srch_q.mask) : '0;
    assign result_o = srch_q.result;

    // R5: at most one trial bit at a time
    a_r5_one_trial: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(srch_q.mask));

    // R5: search opens on the MSB
    a_r5_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
        (go_i && !kill_i) |=> (srch_q.mask == MSB_BIT));

    // R5: trial bit walks toward the LSB
    a_r5_walk_down: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_q.active && !srch_q.mask[0] && !kill_i)
        |=> (srch_q.mask == ($past(srch_q.mask) >> 1)));

endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
    import sar_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int NUM_CH   = 6,
    parameter int DLY_W    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_we,
    input  logic [1:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                afe_power,
    output logic [2:0]          afe_chan,
    output logic [RES_BITS-1:0] dac_code,
    input  logic                cmp_in,
    output logic                irq
);

    logic [RES_BITS-1:0] result_w;
    logic                busy_w, end_w, start_w, stop_w, go_w, done_w, kill_w;
    logic [DLY_W-1:0]    dly_w;

    assign kill_w = start_w || stop_w;

    sar_regs #(
        .RES_BITS (RES_BITS),
        .NUM_CH   (NUM_CH),
        .DLY_W    (DLY_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .result_i  (result_w),
        .busy_i    (busy_w),
        .end_i     (end_w),
        .start_o   (start_w),
        .stop_o    (stop_w),
        .chan_o    (afe_chan),
        .pwr_o     (afe_power),
        .done_o    (done_w),
        .irq_o     (irq),
        .dly_o     (dly_w)
    );

    sar_seq #(
        .DLY_W (DLY_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_w),
        .stop_i  (stop_w),
        .dly_i   (dly_w),
        .end_i   (end_w),
        .busy_o  (busy_w),
        .go_o    (go_w)
    );

    sar_search #(
        .RES_BITS (RES_BITS)
    ) u_search (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (go_w),
        .kill_i   (kill_w),
        .cmp_i    (cmp_in),
        .dac_o    (dac_code),
        .result_o (result_w),
        .end_o    (end_w)
    );

    // R3: never busy with the front end unpowered
    a_r3_busy_powered: assert property (@(posedge clk) disable iff (!rst_n)
        busy_w |-> afe_power);

    // R7: flag and busy never overlap
    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_w |-> !busy_w);

    // R7: interrupt only with a completed conversion
    a_r7_irq_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done_w);

    // R5: DAC quiet outside a conversion
    a_r5_dac_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_w |-> (dac_code == '0));

endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int RES  = 10;
    localparam int NCH  = 6;
    localparam int DLYW = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_we = 1'b0;
    logic [1:0]      bus_addr = 2'd0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic            afe_power;
    logic [2:0]      afe_chan;
    logic [RES-1:0]  dac_code;
    logic            cmp_in;
    logic            irq;
    logic [RES-1:0]  vin_ch [8];

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign cmp_in = (vin_ch[afe_chan] >= dac_code);

    sar_adc_ctrl #(.RES_BITS(RES), .NUM_CH(NCH), .DLY_W(DLYW)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .afe_power(afe_power),
        .afe_chan(afe_chan), .dac_code(dac_code), .cmp_in(cmp_in), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // starts a conversion and waits for the flag; n = negedges after the accepting edge
    task automatic convert(input int ch, input bit ie, output int n, output int first_dac,
                           output logic [RES-1:0] first_val, output bit busy_bad);
        logic [31:0] c, s;
        wr(2'd2, (32'(ie) << 5) | 32'h8 | 32'(ch));
        n = 0; first_dac = -1; first_val = '0; busy_bad = 1'b0;
        while (n < 100000) begin
            rd(2'd2, c);
            if (c[6]) break;
            rd(2'd1, s);
            if (!s[0]) busy_bad = 1'b1;
            if (dac_code != '0 && first_dac < 0) begin
                first_dac = n; first_val = dac_code;
            end
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n, fd, dp;
        logic [RES-1:0] fv;
        bit bb;
        int dl [6] = '{0, 1, 2, 3, 8, 20};

        for (int k = 0; k < 8; k++) vin_ch[k] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check("R1 reset register", r, 32'h0);
        end
        check("R8 reset power", {31'b0, afe_power}, 32'h0);
        check("R7 reset irq", {31'b0, irq}, 32'h0);
        check("R5 reset dac", 32'(dac_code), 32'h0);

        // R1: delay register width
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3, r);
        check("R1 delay readback", r, 32'h0000_FFFF);
        wr(2'd3, 32'd8);
        rd(2'd3, r);
        check("R1 delay readback 8", r, 32'd8);

        // R2/R3: field masking and start
        vin_ch[2] = 10'd613;
        wr(2'd2, 32'hFFFF_FFFA);
        rd(2'd2, r);
        check("R2 ctrl field mask", r, 32'h2A);
        rd(2'd1, r);
        check("R3 busy after start", r, 32'h1);
        check("R3 power on", {31'b0, afe_power}, 32'h1);
        check("R3 channel out", 32'(afe_chan), 32'd2);
        repeat (RES + 10) @(negedge clk);
        rd(2'd2, r);
        check("R2 ctrl with done", r, 32'h6A);
        rd(2'd0, r);
        check("R5 result ch2", r, 32'd613);
        check("R7 irq enabled", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0);
        rd(2'd2, r);
        check("R8 write zero clears", r, 32'h0);
        check("R8 irq cleared", {31'b0, irq}, 32'h0);
        check("R8 power off", {31'b0, afe_power}, 32'h0);

        // R4/R5: delay sweep
        foreach (dl[i]) begin
            wr(2'd3, 32'(dl[i]));
            vin_ch[3] = RES'(dl[i] * 37 + 5);
            dp = (dl[i] < 1) ? 1 : dl[i];
            convert(3, 1'b0, n, fd, fv, bb);
            check("R4 done latency", 32'(n), 32'(dp + RES));
            check("R5 first trial cycle", 32'(fd), 32'(dp));
            check("R5 first trial msb", 32'(fv), 32'h200);
            check("R3 busy throughout", {31'b0, bb}, 32'h0);
            rd(2'd0, r);
            check("R5 result delay sweep", r, 32'(dl[i] * 37 + 5));
            rd(2'd2, r);
            check("R2 ctrl after done", r, 32'h4B);
            check("R7 irq masked", {31'b0, irq}, 32'h0);
        end

        // R3: channel routing
        for (int k = 0; k < 8; k++) vin_ch[k] = RES'(k * 170 + 7);
        wr(2'd3, 32'd2);
        for (int ch = 0; ch < NCH; ch++) begin
            convert(ch, 1'b1, n, fd, fv, bb);
            rd(2'd0, r);
            check("R3 channel select result", r, 32'(ch * 170 + 7));
        end

        // R5/R6: full code sweep on one channel
        wr(2'd3, 32'd1);
        for (int v = 0; v < (1 << RES); v++) begin
            vin_ch[1] = RES'(v);
            convert(1, 1'b1, n, fd, fv, bb);
            rd(2'd0, r);
            check("R6 result word sweep", r, 32'(v));
        end

        // R6: stable while flag high
        vin_ch[1] = '0;
        repeat (10) @(negedge clk);
        rd(2'd0, r);
        check("R6 result held", r, 32'd1023);
        check("R5 dac idle", 32'(dac_code), 32'h0);
        check("R7 irq held", {31'b0, irq}, 32'h1);

        // R8: abort mid-search
        wr(2'd3, 32'd4);
        vin_ch[0] = 10'd300;
        wr(2'd2, 32'h28);
        repeat (6) @(negedge clk);
        rd(2'd1, r);
        check("R3 busy mid-search", r, 32'h1);
        wr(2'd2, 32'h0);
        rd(2'd1, r);
        check("R8 abort busy", r, 32'h0);
        check("R8 abort power", {31'b0, afe_power}, 32'h0);
        check("R8 abort dac", 32'(dac_code), 32'h0);
        repeat (20) @(negedge clk);
        rd(2'd2, r);
        check("R8 abort no done", r, 32'h0);

        // R9: rejected channel after completion
        vin_ch[4] = 10'd77;
        convert(4, 1'b1, n, fd, fv, bb);
        wr(2'd2, 32'h2E);
        rd(2'd2, r);
        check("R9 reject keeps ctrl", r, 32'h6C);
        check("R9 reject keeps irq", {31'b0, irq}, 32'h1);
        check("R9 reject keeps chan", 32'(afe_chan), 32'd4);
        wr(2'd2, 32'h07);
        repeat (20) @(negedge clk);
        rd(2'd1, r);
        check("R9 reject no busy", r, 32'h0);
        rd(2'd2, r);
        check("R9 reject power-down form", r, 32'h6C);
        wr(2'd2, 32'h0);
        wr(2'd2, 32'h0F);
        rd(2'd2, r);
        check("R9 reject from idle", r, 32'h0);
        repeat (20) @(negedge clk);
        rd(2'd2, r);
        check("R9 no done from reject", r, 32'h0);
        check("R9 power stays off", {31'b0, afe_power}, 32'h0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule